// File: doc/BRIEF.md
# Dual Calendar Alarm Comparator

This block keeps two independent alarm slots. Each slot is compared against the running BCD calendar. A host writes into a slot a stored value for each of six time fields, a per-field enable mask, a repeat selector and an arm bit. The comparison is made only when the once-per-second update strobe is high. If every enabled field of an armed slot equals the live calendar at that moment, the slot's flag is set.

A field whose enable bit is clear is a don't-care, so any subset of fields can form the alarm. A slot with an empty mask is never satisfied. In one-shot mode, firing disarms the slot. In repeat mode the slot stays armed, which gives a periodic interrupt, for example once a minute when only the seconds field is enabled.

Flags are sticky. Software can poll them, and it clears them by writing ones to `flag_clr`. An active-low interrupt line is asserted while any flag that is not masked is set.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset every flag and every arm bit is 0 and `irq_n` is 1.
- R2: When `tick_1hz` is high at a clock edge and an armed slot's enabled fields all equal `now_bcd`, that slot's flag reads 1 from the next cycle on. A mismatch in any enabled field leaves the flag unchanged. Field positions in `now_bcd` and `cfg_val` are: seconds [7:0], minutes [15:8], hours [23:16], day of week [31:24], date [39:32], month [47:40]. Enable bit i selects field i.
- R3: A field whose enable bit is 0 is treated as matching, whatever its stored or live value.
- R4: A slot whose enable mask is all zero never sets its flag.
- R5: Without `tick_1hz` no flag is set, even when the fields match.
- R6: In one-shot mode (`cfg_repeat`=0), `alarm_armed` of a slot drops to 0 in the cycle after the slot fires, and the slot does not fire again until it is rewritten.
- R7: In repeat mode (`cfg_repeat`=1) the slot stays armed after firing and fires again on the next matching strobe.
- R8: A flag stays set until a 1 is written to its bit of `flag_clr`. A 0 bit has no effect. If a fire and a clear reach the same slot at the same edge, the flag stays set.
- R9: `irq_n` is 0 exactly while some slot has its flag set and its `irq_mask` bit at 0 (a 1 masks that slot). It follows the mask without delay.
- R10: The two slots are independent. Programming, firing or clearing one leaves the other's flag and arm bit unchanged.
- R11: A slot that is not armed never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second, when the calendar updates |
| now_bcd | input | 48 | Live BCD calendar, six 8-bit fields |
| cfg_wr | input | 1 | Write strobe for one slot's configuration |
| cfg_idx | input | 1 | Slot selected by the write |
| cfg_val | input | 48 | Stored field values, same layout as `now_bcd` |
| cfg_en | input | 6 | Per-field enable mask |
| cfg_repeat | input | 1 | 1 = repeat mode, 0 = one-shot |
| cfg_arm | input | 1 | Arm bit loaded with the write |
| flag_clr | input | 2 | Write-one-to-clear of the slot flags |
| irq_mask | input | 2 | 1 masks that slot from the interrupt |
| alarm_flag | output | 2 | Sticky per-slot flags |
| alarm_armed | output | 2 | Per-slot arm state |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench targets the don't-care rule and the empty mask together. A design that treated an empty mask as "all match" would fire on every strobe, and one that compared disabled fields would miss a seconds-only periodic alarm. It strikes a one-shot slot a second time after clearing its flag, which catches a slot that fails to disarm, and it checks that a repeat slot is re-fired. It also issues a clear together with a fire to pin the set-over-clear priority, and it toggles the mask with a flag held so that a registered or inverted interrupt path is exposed.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int FIELD_W    = 8;
  localparam int TIME_W     = NUM_FIELDS * FIELD_W;

  // All enabled fields equal and at least one field enabled.
  function automatic logic fields_match(input logic [TIME_W-1:0] now,
                                        input logic [TIME_W-1:0] val,
                                        input logic [NUM_FIELDS-1:0] en);
    logic [NUM_FIELDS-1:0] eq;
    for (int f = 0; f < NUM_FIELDS; f++)
      eq[f] = (now[f*FIELD_W +: FIELD_W] == val[f*FIELD_W +: FIELD_W]);
    return (|en) && (&(eq | ~en));
  endfunction
endpackage

// File: rtl/alarm_slot.sv
module alarm_slot
  import alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [TIME_W-1:0]     now,
  input  logic                  wr,
  input  logic [TIME_W-1:0]     wr_val,
  input  logic [NUM_FIELDS-1:0] wr_en,
  input  logic                  wr_repeat,
  input  logic                  wr_arm,
  input  logic                  clr,
  output logic                  flag,
  output logic                  armed
);
  logic [TIME_W-1:0]     val_q;
  logic [NUM_FIELDS-1:0] en_q;
  logic                  rep_q;
  logic                  armed_q;
  logic                  flag_q;
  logic                  fields_ok;
  logic                  hit;

  assign fields_ok = fields_match(now, val_q, en_q);
  assign hit       = tick && armed_q && fields_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      en_q    <= '0;
      rep_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (wr) begin
      val_q   <= wr_val;
      en_q    <= wr_en;
      rep_q   <= wr_repeat;
      armed_q <= wr_arm;
    end else if (hit && !rep_q) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag  = flag_q;
  assign armed = armed_q;

  assert_hit_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  assert_empty_mask_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !hit);
  assert_rise_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick));
  assert_oneshot_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !rep_q && !wr) |=> !armed_q);
  assert_repeat_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rep_q && !wr) |=> armed_q);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  assert_rise_needs_arm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(armed_q));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int N = 2
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] mask,
  output logic         irq_n
);
  logic [N-1:0] live;
  assign live  = flags & ~mask;
  assign irq_n = ~(|live);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int NUM_ALARMS = 2,
  localparam int IDX_W = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_1hz,
  input  logic [TIME_W-1:0]     now_bcd,
  input  logic                  cfg_wr,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic [TIME_W-1:0]     cfg_val,
  input  logic [NUM_FIELDS-1:0] cfg_en,
  input  logic                  cfg_repeat,
  input  logic                  cfg_arm,
  input  logic [NUM_ALARMS-1:0] flag_clr,
  input  logic [NUM_ALARMS-1:0] irq_mask,
  output logic [NUM_ALARMS-1:0] alarm_flag,
  output logic [NUM_ALARMS-1:0] alarm_armed,
  output logic                  irq_n
);
  logic [NUM_ALARMS-1:0] slot_wr;

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_slot
    assign slot_wr[g] = cfg_wr && (cfg_idx == IDX_W'(g));
    alarm_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_1hz),
      .now       (now_bcd),
      .wr        (slot_wr[g]),
      .wr_val    (cfg_val),
      .wr_en     (cfg_en),
      .wr_repeat (cfg_repeat),
      .wr_arm    (cfg_arm),
      .clr       (flag_clr[g]),
      .flag      (alarm_flag[g]),
      .armed     (alarm_armed[g])
    );
  end

  irq_combine #(.N(NUM_ALARMS)) u_irq (
    .flags (alarm_flag),
    .mask  (irq_mask),
    .irq_n (irq_n)
  );

  assert_irq_low_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (alarm_flag != '0));
endmodule

// File: tb/alarm_match_unit_tb_top.sv
module alarm_match_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;

  typedef struct {
    string          tag;
    logic [N-1:0]   flag;
    logic [N-1:0]   armed;
    logic           irq_n;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_1hz = 1'b0;
  logic [47:0]   now_bcd = '0;
  logic          cfg_wr = 1'b0;
  logic [0:0]    cfg_idx = '0;
  logic [47:0]   cfg_val = '0;
  logic [5:0]    cfg_en = '0;
  logic          cfg_repeat = 1'b0;
  logic          cfg_arm = 1'b0;
  logic [N-1:0]  flag_clr = '0;
  logic [N-1:0]  irq_mask = '0;
  logic [N-1:0]  alarm_flag;
  logic [N-1:0]  alarm_armed;
  logic          irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];
  event chk_ev;

  // bench model
  logic [47:0] m_val [N];
  logic [5:0]  m_en  [N];
  logic [N-1:0] m_rep = '0, m_armed = '0, m_flag = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_match_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .now_bcd(now_bcd),
    .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_val(cfg_val), .cfg_en(cfg_en),
    .cfg_repeat(cfg_repeat), .cfg_arm(cfg_arm), .flag_clr(flag_clr),
    .irq_mask(irq_mask), .alarm_flag(alarm_flag), .alarm_armed(alarm_armed),
    .irq_n(irq_n)
  );

  function automatic logic [47:0] mk(input logic [7:0] mon, dt, dw, hr, mn, sc);
    return {mon, dt, dw, hr, mn, sc};
  endfunction

  function automatic bit bmatch(input logic [47:0] t, input logic [47:0] v, input logic [5:0] e);
    bit any = 0;
    for (int f = 0; f < 6; f++) begin
      if (e[f]) begin
        any = 1;
        if (t[f*8 +: 8] !== v[f*8 +: 8]) return 0;
      end
    end
    return any;
  endfunction

  task automatic final_report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: all tasks start and end just after a falling edge
  task automatic program_slot(input int a, input logic [47:0] v, input logic [5:0] e,
                              input logic rep, input logic arm);
    cfg_wr = 1; cfg_idx = a[0:0]; cfg_val = v; cfg_en = e; cfg_repeat = rep; cfg_arm = arm;
    @(negedge clk);
    cfg_wr = 0;
    m_val[a] = v; m_en[a] = e; m_rep[a] = rep; m_armed[a] = arm;
  endtask

  task automatic step(input logic tk, input logic [N-1:0] clr);
    tick_1hz = tk; flag_clr = clr;
    for (int a = 0; a < N; a++) begin
      bit h;
      h = tk && m_armed[a] && bmatch(now_bcd, m_val[a], m_en[a]);
      if (h) begin
        m_flag[a] = 1'b1;
        if (!m_rep[a]) m_armed[a] = 1'b0;
      end else if (clr[a]) begin
        m_flag[a] = 1'b0;
      end
    end
    @(negedge clk);
    tick_1hz = 0; flag_clr = '0;
  endtask

  task automatic expect_now(input string tag);
    exp_t it;
    it.tag = tag; it.flag = m_flag; it.armed = m_armed;
    it.irq_n = ~(|(m_flag & ~irq_mask));
    q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (alarm_flag !== it.flag || alarm_armed !== it.armed || irq_n !== it.irq_n) begin
          errors++;
          $display("FAIL %s: actual flag=%b armed=%b irq_n=%b expected flag=%b armed=%b irq_n=%b",
                   it.tag, alarm_flag, alarm_armed, irq_n, it.flag, it.armed, it.irq_n);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      final_report();
    end
  end

  initial begin
    logic [47:0] t0;
    for (int a = 0; a < N; a++) begin m_val[a] = '0; m_en[a] = '0; end
    t0 = mk(8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h45);
    now_bcd = t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_now("R1 reset state");

    program_slot(0, t0, 6'h3F, 0, 0);
    step(1, '0);
    expect_now("R11 unarmed slot ignores match");

    program_slot(0, t0, 6'h3F, 0, 1);
    step(0, '0); step(0, '0); step(0, '0);
    expect_now("R5 no strobe no fire");

    step(1, '0);
    expect_now("R2 R6 R9 one-shot fire");
    step(1, '0);
    expect_now("R8 flag sticky while disarmed");
    step(0, 2'b01);
    expect_now("R8 write-one clears flag");
    step(1, '0);
    expect_now("R6 one-shot stays disarmed");

    // seconds-only periodic alarm in slot 1
    now_bcd = mk(8'h12, 8'h31, 8'h03, 8'h23, 8'h10, 8'h45);
    program_slot(1, mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h45), 6'h01, 1, 1);
    expect_now("R10 programming slot1 leaves slot0");
    step(1, '0);
    expect_now("R3 R7 don't-care fields, repeat fire");
    step(0, 2'b10);
    expect_now("R8 clear slot1");
    now_bcd = mk(8'h01, 8'h02, 8'h05, 8'h07, 8'h11, 8'h45);
    step(1, '0);
    expect_now("R7 repeat fires again");

    irq_mask = 2'b10;
    #1;
    expect_now("R9 masked flag releases irq");
    irq_mask = 2'b00;
    #1;
    expect_now("R9 unmasked flag asserts irq");

    step(0, 2'b00);
    expect_now("R8 zero clear no effect");
    step(1, 2'b10);
    expect_now("R8 set wins over clear");
    step(0, 2'b11);
    expect_now("R8 clear all");

    program_slot(0, now_bcd, 6'h00, 1, 1);
    step(1, '0);
    expect_now("R4 empty mask never fires");
    step(0, 2'b10);

    program_slot(0, mk(8'h01, 8'h02, 8'h05, 8'h07, 8'h11, 8'h46), 6'h3F, 0, 1);
    step(1, '0);
    expect_now("R2 R10 seconds mismatch, slot1 fires alone");
    step(0, 2'b10);
    now_bcd = mk(8'h01, 8'h02, 8'h05, 8'h07, 8'h11, 8'h46);
    step(1, '0);
    expect_now("R10 slot0 fires, slot1 independent");

    program_slot(1, mk(8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00), 6'h30, 0, 1);
    step(0, 2'b01);
    now_bcd = mk(8'h01, 8'h02, 8'h06, 8'h08, 8'h33, 8'h12);
    step(1, '0);
    expect_now("R3 month and date only match");

    program_slot(1, mk(8'h01, 8'h02, 8'h06, 8'h09, 8'h33, 8'h12), 6'h3F, 1, 1);
    step(1, '0);
    expect_now("R2 hour mismatch no fire");

    done = 1;
    final_report();
  end
endmodule